// File: doc/BRIEF.md
# Host Bridge Outbound Window Translator

This block is the control register file of a host-to-PCI bridge together with the address translator that uses it. Software programs eight 32-bit registers over a simple register bus. Three of them are window-map registers, one for each outbound memory window. Three are secondary map registers. The last two are an identity word and a flags word. The last five are storage only: the block keeps them and returns them on reads, and gives them no other meaning.

A requester that has already decoded which outbound window a system access falls in presents the window number and the byte offset into that window. The block returns the 32-bit PCI address and a hit flag. Window number 3 selects a fixed I/O window that starts at PCI I/O address 0. The base address of each memory window is derived from its window-map register. How it is derived depends on a board-variant input.

On the primary board, the low nibble of the map register becomes PCI address bits 31:28. On the alternate board, the map register is masked down to the window's power-of-two size. The translation is combinational from the register state, so a new map value applies from the cycle after the write.

Top module: `pcib_window_xlate`

## Requirements
- R1: Word-aligned 32-bit accesses reach these registers: window map 0/1/2 at offsets 0x00, 0x04 and 0x08, identity at 0x0C, flags at 0x10, and secondary map 0/1/2 at 0x14, 0x18 and 0x1C. A read returns the full 32-bit value last written.
- R2: A write to any other offset, or to an offset whose bits 1:0 are not 00, changes no register. A read of such an offset returns 0.
- R3: Only accesses with reg_size = 2'b10 (32-bit) take effect. A write of any other size changes nothing, and a read of any other size returns 0 with reg_rvalid still asserted.
- R4: While rst_n is low at a clock edge, all eight registers clear to 0, reg_rvalid clears to 0, and every window base becomes 0.
- R5: reg_rvalid is high exactly in the cycle after a cycle in which reg_rd_en was high. reg_rdata is 0 whenever reg_rvalid is low. A read in the same cycle as a write returns the value from before the write.
- R6: With alt_board = 0, the base of memory window i is map register i bits 3:0 shifted up to PCI address bits 31:28. All other map bits are ignored.
- R7: With alt_board = 1, the base of memory window i is map register i ANDed with the complement of (window size − 1).
- R8: Window sizes are 0x0C000000, 0x10000000 and 0x10000000 with alt_board = 0, and 0x01000000, 0x04000000 and 0x08000000 with alt_board = 1. pci_hit is 1 exactly when xl_offset is below the selected size. On a miss, pci_addr is 0.
- R9: xl_sel = 3 selects the I/O window. pci_addr equals xl_offset, and the hit threshold is 0x100000, regardless of the registers and of alt_board.
- R10: A write to a window-map register changes that window's translation from the cycle after the write edge.
- R11: On a hit, pci_addr equals the window base plus xl_offset, modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_size | input | 2 | Access size, 2'b10 = 32-bit |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| reg_rvalid | output | 1 | Read data valid, one cycle after the read strobe |
| alt_board | input | 1 | Board variant: 0 primary, 1 alternate |
| xl_sel | input | 2 | Window select: 0 to 2 memory windows, 3 the I/O window |
| xl_offset | input | 32 | Byte offset into the selected window |
| pci_addr | output | 32 | Translated PCI address, 0 on a miss |
| pci_hit | output | 1 | Offset lies inside the selected window |

## Verification
The bench pushes the upper bits of the map registers to all ones. A translator that shifts the whole register, or forgets to mask on the alternate board, then produces a wrong base on the first probe. It probes every window at offsets size − 1 and size and at the top of the 32-bit range under both variants. Both window sizes of one board are used against each variant, so an off-by-one compare, swapped size tables, or a missing zero on a miss shows up as a wrong hit flag or a stale address. It writes to unmapped, misaligned and narrow offsets and then rereads every real register. A decoder that aliases those offsets corrupts a register, and a read path that does not zero them returns data. It also changes a map register while a translation is held steady, which exposes a base that updates a cycle late or not at all.

// File: rtl/pcib_xlate_pkg.sv
// Package: shared types and the register-offset decoder of the window translator.
// Assumes at most 16 windows per register group (4-bit index).
package pcib_xlate_pkg;

    localparam logic [1:0] ACC_WORD = 2'b10;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_WMAP,
        RK_SELF,
        RK_FLAG,
        RK_SMAP
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e   kind;
        logic [3:0]  idx;
    } reg_sel_t;

    // Map a byte offset and access size onto a register group and index.
    function automatic reg_sel_t decode_reg(input logic [31:0] addr,
                                            input logic [1:0]  size,
                                            input int unsigned num_win);
        reg_sel_t    r;
        int unsigned w;
        r.kind = RK_NONE;
        r.idx  = '0;
        w      = {2'b00, addr[31:2]};
        if (size == ACC_WORD && addr[1:0] == 2'b00) begin
            if (w < num_win) begin
                r.kind = RK_WMAP;
                r.idx  = 4'(w);
            end else if (w == num_win) begin
                r.kind = RK_SELF;
            end else if (w == num_win + 1) begin
                r.kind = RK_FLAG;
            end else if (w < 2 * num_win + 2) begin
                r.kind = RK_SMAP;
                r.idx  = 4'(w - num_win - 2);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/pcib_ctrl_regs.sv
// Module: control register file of the bridge.
// Holds the window-map, secondary-map, identity and flags words. Only aligned
// word accesses take effect; anything else is dropped on write and reads as 0.
// Read data is registered and reflects the state before a same-cycle write.
module pcib_ctrl_regs #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NUM_WIN = 3,
    parameter int unsigned REG_AW  = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic                            rd_en,
    input  logic [REG_AW-1:0]               addr,
    input  logic [1:0]                      size,
    input  logic [DATA_W-1:0]               wdata,
    output logic [DATA_W-1:0]               rdata,
    output logic                            rvalid,
    output logic [NUM_WIN-1:0][DATA_W-1:0]  win_map
);
    import pcib_xlate_pkg::*;

    logic [NUM_WIN-1:0][DATA_W-1:0] wmap_q;
    logic [NUM_WIN-1:0][DATA_W-1:0] smap_q;
    logic [DATA_W-1:0]              self_q;
    logic [DATA_W-1:0]              flag_q;
    reg_sel_t                       sel_c;
    logic [DATA_W-1:0]              rd_mux;

    assign sel_c   = decode_reg(32'(addr), size, NUM_WIN);
    assign win_map = wmap_q;

    // Register writes: clear on reset, otherwise load the decoded register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wmap_q <= '0;
            smap_q <= '0;
            self_q <= '0;
            flag_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < int'(NUM_WIN); i++) begin
                if (sel_c.kind == RK_WMAP && sel_c.idx == 4'(i)) wmap_q[i] <= wdata;
                if (sel_c.kind == RK_SMAP && sel_c.idx == 4'(i)) smap_q[i] <= wdata;
            end
            if (sel_c.kind == RK_SELF) self_q <= wdata;
            if (sel_c.kind == RK_FLAG) flag_q <= wdata;
        end
    end

    // Read multiplexer over the current register state.
    always_comb begin
        rd_mux = '0;
        case (sel_c.kind)
            RK_WMAP: begin
                for (int i = 0; i < int'(NUM_WIN); i++)
                    if (sel_c.idx == 4'(i)) rd_mux = wmap_q[i];
            end
            RK_SMAP: begin
                for (int i = 0; i < int'(NUM_WIN); i++)
                    if (sel_c.idx == 4'(i)) rd_mux = smap_q[i];
            end
            RK_SELF: rd_mux = self_q;
            RK_FLAG: rd_mux = flag_q;
            default: rd_mux = '0;
        endcase
    end

    // Read return stage: data and valid one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_en;
            rdata  <= rd_en ? rd_mux : '0;
        end
    end

endmodule

// File: rtl/pcib_win_base.sv
// Module: base address of one outbound memory window.
// Primary board: map nibble becomes the top nibble of the PCI address.
// Alternate board: map word masked to the window's size. Assumes the
// alternate size is a power of two.
module pcib_win_base #(
    parameter int unsigned      DATA_W   = 32,
    parameter int unsigned      NIB_W    = 4,
    parameter logic [31:0]      SIZE_PRI = 32'h1000_0000,
    parameter logic [31:0]      SIZE_ALT = 32'h0100_0000
) (
    input  logic              alt_board,
    input  logic [DATA_W-1:0] map_val,
    output logic [DATA_W-1:0] base,
    output logic [DATA_W-1:0] size
);
    localparam logic [DATA_W-1:0] SZ_PRI   = DATA_W'(SIZE_PRI);
    localparam logic [DATA_W-1:0] SZ_ALT   = DATA_W'(SIZE_ALT);
    localparam logic [DATA_W-1:0] MASK_ALT = ~(SZ_ALT - DATA_W'(1));

    logic [DATA_W-1:0] base_pri;
    logic [DATA_W-1:0] base_alt;

    assign base_pri = {map_val[NIB_W-1:0], {(DATA_W-NIB_W){1'b0}}};
    assign base_alt = map_val & MASK_ALT;

    // Pick base and size for the board in use.
    always_comb begin
        base = alt_board ? base_alt : base_pri;
        size = alt_board ? SZ_ALT : SZ_PRI;
    end

endmodule

// File: rtl/pcib_addr_xlate.sv
// Module: offset-to-PCI-address translation for the selected window.
// Select values below NUM_WIN pick a memory window, NUM_WIN picks the fixed
// I/O window at base 0, anything above misses. Purely combinational.
module pcib_addr_xlate #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NUM_WIN = 3,
    parameter int unsigned SEL_W   = 2,
    parameter logic [31:0] IO_SIZE = 32'h0010_0000
) (
    input  logic [SEL_W-1:0]               sel,
    input  logic [DATA_W-1:0]              offset,
    input  logic [NUM_WIN-1:0][DATA_W-1:0] bases,
    input  logic [NUM_WIN-1:0][DATA_W-1:0] sizes,
    output logic [DATA_W-1:0]              pci_addr,
    output logic                           pci_hit
);
    localparam logic [SEL_W-1:0]  IO_SEL = SEL_W'(NUM_WIN);
    localparam logic [DATA_W-1:0] IO_SZ  = DATA_W'(IO_SIZE);

    logic [DATA_W-1:0] cur_base;
    logic [DATA_W-1:0] cur_size;
    logic              sel_ok;
    logic              in_range;

    // Select base and size of the addressed window.
    always_comb begin
        cur_base = '0;
        cur_size = '0;
        sel_ok   = 1'b0;
        if (sel == IO_SEL) begin
            cur_size = IO_SZ;
            sel_ok   = 1'b1;
        end else begin
            for (int i = 0; i < int'(NUM_WIN); i++) begin
                if (sel == SEL_W'(i)) begin
                    cur_base = bases[i];
                    cur_size = sizes[i];
                    sel_ok   = 1'b1;
                end
            end
        end
    end

    // Range check and sum; a miss drives a zero address.
    always_comb begin
        in_range = sel_ok && (offset < cur_size);
        pci_hit  = in_range;
        pci_addr = in_range ? (cur_base + offset) : '0;
    end

endmodule

// File: rtl/pcib_window_xlate.sv
// Module: top of the host bridge window translator.
// Register file plus one base unit per memory window plus the translator.
// Assumes the requester has already decoded which window an access hits.
module pcib_window_xlate #(
    parameter int unsigned                   DATA_W    = 32,
    parameter int unsigned                   NUM_WIN   = 3,
    parameter int unsigned                   REG_AW    = 8,
    parameter int unsigned                   NIB_W     = 4,
    parameter logic [31:0]                   IO_SIZE   = 32'h0010_0000,
    parameter logic [NUM_WIN-1:0][31:0]      PRI_SIZES = {32'h1000_0000, 32'h1000_0000, 32'h0C00_0000},
    parameter logic [NUM_WIN-1:0][31:0]      ALT_SIZES = {32'h0800_0000, 32'h0400_0000, 32'h0100_0000},
    localparam int unsigned                  SEL_W     = $clog2(NUM_WIN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [1:0]        reg_size,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_rvalid,
    input  logic              alt_board,
    input  logic [SEL_W-1:0]  xl_sel,
    input  logic [DATA_W-1:0] xl_offset,
    output logic [DATA_W-1:0] pci_addr,
    output logic              pci_hit
);
    logic [NUM_WIN-1:0][DATA_W-1:0] win_map;
    logic [NUM_WIN-1:0][DATA_W-1:0] win_base;
    logic [NUM_WIN-1:0][DATA_W-1:0] win_size;

    pcib_ctrl_regs #(
        .DATA_W (DATA_W),
        .NUM_WIN(NUM_WIN),
        .REG_AW (REG_AW)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr_en),
        .rd_en  (reg_rd_en),
        .addr   (reg_addr),
        .size   (reg_size),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .rvalid (reg_rvalid),
        .win_map(win_map)
    );

    // One base unit per memory window.
    for (genvar gi = 0; gi < int'(NUM_WIN); gi++) begin : g_win
        pcib_win_base #(
            .DATA_W  (DATA_W),
            .NIB_W   (NIB_W),
            .SIZE_PRI(PRI_SIZES[gi]),
            .SIZE_ALT(ALT_SIZES[gi])
        ) u_base (
            .alt_board(alt_board),
            .map_val  (win_map[gi]),
            .base     (win_base[gi]),
            .size     (win_size[gi])
        );
    end

    pcib_addr_xlate #(
        .DATA_W (DATA_W),
        .NUM_WIN(NUM_WIN),
        .SEL_W  (SEL_W),
        .IO_SIZE(IO_SIZE)
    ) u_xlate (
        .sel     (xl_sel),
        .offset  (xl_offset),
        .bases   (win_base),
        .sizes   (win_size),
        .pci_addr(pci_addr),
        .pci_hit (pci_hit)
    );

endmodule

// File: rtl/pcib_xlate_checker.sv
// Module: protocol and translation properties of the window translator,
// attached to the top by the bind at the end of this file.
module pcib_xlate_checker #(
    parameter int unsigned              DATA_W    = 32,
    parameter int unsigned              NUM_WIN   = 3,
    parameter int unsigned              REG_AW    = 8,
    parameter int unsigned              SEL_W     = 2,
    parameter logic [31:0]              IO_SIZE   = 32'h0010_0000,
    parameter logic [NUM_WIN-1:0][31:0] PRI_SIZES = {32'h1000_0000, 32'h1000_0000, 32'h0C00_0000}
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic              reg_rd_en,
    input logic [REG_AW-1:0] reg_addr,
    input logic [1:0]        reg_size,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              reg_rvalid,
    input logic              alt_board,
    input logic [SEL_W-1:0]  xl_sel,
    input logic [DATA_W-1:0] xl_offset,
    input logic [DATA_W-1:0] pci_addr,
    input logic              pci_hit
);
    localparam logic [REG_AW-1:0] MAP_END = REG_AW'(4 * (2 * NUM_WIN + 2));
    localparam logic [SEL_W-1:0]  IO_SEL  = SEL_W'(NUM_WIN);
    localparam logic [DATA_W-1:0] IO_SZ   = DATA_W'(IO_SIZE);
    localparam logic [DATA_W-1:0] SZ0     = DATA_W'(PRI_SIZES[0]);

    p_rvalid_after_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && reg_rd_en) |=> reg_rvalid);

    p_no_rvalid_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !reg_rd_en) |=> !reg_rvalid);

    p_rdata_zero_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rvalid |-> reg_rdata == '0);

    p_unmapped_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && reg_rd_en && reg_size == 2'b10 && reg_addr >= MAP_END) |=> reg_rdata == '0);

    p_narrow_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && reg_rd_en && reg_size != 2'b10) |=> (reg_rvalid && reg_rdata == '0));

    p_miss_addr_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pci_hit |-> pci_addr == '0);

    p_beyond_window_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!alt_board && xl_sel == '0 && xl_offset >= SZ0) |-> !pci_hit);

    p_io_passthru_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_sel == IO_SEL && xl_offset < IO_SZ) |-> (pci_hit && pci_addr == xl_offset));

    p_map_write_applies_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && reg_wr_en && reg_size == 2'b10 && reg_addr == '0)
        ##1 (!alt_board && xl_sel == '0 && xl_offset == '0)
        |-> pci_addr == {$past(reg_wdata[3:0]), {(DATA_W-4){1'b0}}});

endmodule

bind pcib_window_xlate pcib_xlate_checker #(
    .DATA_W   (DATA_W),
    .NUM_WIN  (NUM_WIN),
    .REG_AW   (REG_AW),
    .SEL_W    (SEL_W),
    .IO_SIZE  (IO_SIZE),
    .PRI_SIZES(PRI_SIZES)
) u_pcib_xlate_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .reg_rd_en (reg_rd_en),
    .reg_addr  (reg_addr),
    .reg_size  (reg_size),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .reg_rvalid(reg_rvalid),
    .alt_board (alt_board),
    .xl_sel    (xl_sel),
    .xl_offset (xl_offset),
    .pci_addr  (pci_addr),
    .pci_hit   (pci_hit)
);

// File: tb/pcib_window_xlate_bench.sv
// Bench: behavioural reference model compared against the design on every clock.
module pcib_window_xlate_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_en = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [1:0]  reg_size = 2'b10;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic        alt_board = 1'b0;
    logic [1:0]  xl_sel = '0;
    logic [31:0] xl_offset = '0;
    logic [31:0] pci_addr;
    logic        pci_hit;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;
    string cur_tag = "R4";

    // Reference state
    logic [31:0] m_wmap [3];
    logic [31:0] m_smap [3];
    logic [31:0] m_self, m_flag, m_rdata;
    logic        m_rvalid;
    logic [31:0] pri_sz [3] = '{32'h0C00_0000, 32'h1000_0000, 32'h1000_0000};
    logic [31:0] alt_sz [3] = '{32'h0100_0000, 32'h0400_0000, 32'h0800_0000};

    pcib_window_xlate u_pcib_window_xlate (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_size(reg_size), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .alt_board(alt_board),
        .xl_sel(xl_sel), .xl_offset(xl_offset), .pci_addr(pci_addr), .pci_hit(pci_hit)
    );

    initial forever #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a, input logic [1:0] sz);
        if (sz != 2'b10) return 32'h0;
        case (a)
            8'h00: return m_wmap[0];
            8'h04: return m_wmap[1];
            8'h08: return m_wmap[2];
            8'h0C: return m_self;
            8'h10: return m_flag;
            8'h14: return m_smap[0];
            8'h18: return m_smap[1];
            8'h1C: return m_smap[2];
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
        if (sz == 2'b10) begin
            case (a)
                8'h00: m_wmap[0] = d;
                8'h04: m_wmap[1] = d;
                8'h08: m_wmap[2] = d;
                8'h0C: m_self = d;
                8'h10: m_flag = d;
                8'h14: m_smap[0] = d;
                8'h18: m_smap[1] = d;
                8'h1C: m_smap[2] = d;
                default: ;
            endcase
        end
    endtask

    task automatic model_edge();
        logic [31:0] rd;
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                m_wmap[i] = '0;
                m_smap[i] = '0;
            end
            m_self = '0; m_flag = '0; m_rdata = '0; m_rvalid = 1'b0;
        end else begin
            rd = reg_rd_en ? model_read(reg_addr, reg_size) : 32'h0;
            if (reg_wr_en) model_write(reg_addr, reg_size, reg_wdata);
            m_rvalid = reg_rd_en;
            m_rdata  = rd;
        end
    endtask

    task automatic model_xlate(output logic [31:0] ea, output logic eh);
        longint base, sz, sum;
        if (xl_sel == 2'd3) begin
            eh = (xl_offset < 32'h0010_0000);
            ea = eh ? xl_offset : 32'h0;
        end else begin
            sz = alt_board ? longint'(alt_sz[xl_sel]) : longint'(pri_sz[xl_sel]);
            if (alt_board) base = longint'(m_wmap[xl_sel]) & (64'hFFFF_FFFF - (sz - 1));
            else base = longint'(m_wmap[xl_sel] & 32'hF) * 64'h1000_0000;
            eh  = (longint'(xl_offset) < sz);
            sum = (base + longint'(xl_offset)) % 64'h1_0000_0000;
            ea  = eh ? 32'(sum) : 32'h0;
        end
    endtask

    // Advance one clock: model the edge, then compare all outputs.
    task automatic tick();
        logic [31:0] ea;
        logic        eh;
        @(negedge clk);
        model_edge();
        model_xlate(ea, eh);
        chk(reg_rvalid == m_rvalid, "R5", "rvalid", 32'(reg_rvalid), 32'(m_rvalid));
        chk(reg_rdata == m_rdata, cur_tag, "rdata", reg_rdata, m_rdata);
        chk(pci_hit == eh, cur_tag, "pci_hit", 32'(pci_hit), 32'(eh));
        chk(pci_addr == ea, cur_tag, "pci_addr", pci_addr, ea);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d; reg_size = sz;
        tick();
        reg_wr_en = 1'b0; reg_size = 2'b10;
    endtask

    task automatic do_read(input logic [7:0] a, input logic [1:0] sz);
        reg_rd_en = 1'b1; reg_addr = a; reg_size = sz;
        tick();
        reg_rd_en = 1'b0; reg_size = 2'b10;
    endtask

    task automatic read_all();
        for (int i = 0; i < 8; i++) do_read(8'(i * 4), 2'b10);
    endtask

    task automatic probe(input logic [1:0] s, input logic [31:0] off);
        xl_sel = s; xl_offset = off;
        tick();
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R4: reset state, then reset after writes
        cur_tag = "R4";
        rst_n = 1'b0;
        repeat (3) tick();
        chk(reg_rvalid == 1'b0 && reg_rdata == 32'h0, "R4", "reset outputs", reg_rdata, 32'h0);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) do_write(8'(i * 4), 32'h1111_1111 * 32'(i + 1), 2'b10);
        rst_n = 1'b0;
        repeat (2) tick();
        rst_n = 1'b1;
        read_all();
        probe(2'd1, 32'h10);
        chk(pci_addr == 32'h10, "R4", "base after reset", pci_addr, 32'h10);

        // R1: every register holds a full word
        cur_tag = "R1";
        for (int i = 0; i < 8; i++) do_write(8'(i * 4), 32'hA5C3_0F00 ^ (32'h0101_0101 * 32'(i)), 2'b10);
        read_all();
        do_read(8'h10, 2'b10);
        chk(reg_rdata == (32'hA5C3_0F00 ^ 32'h0404_0404), "R1", "flags word", reg_rdata, 32'hA5C3_0F00 ^ 32'h0404_0404);

        // R2: unmapped and misaligned offsets
        cur_tag = "R2";
        do_write(8'h20, 32'hDEAD_BEEF, 2'b10);
        do_write(8'hFC, 32'hDEAD_BEEF, 2'b10);
        do_write(8'h01, 32'hDEAD_BEEF, 2'b10);
        do_write(8'h16, 32'hDEAD_BEEF, 2'b10);
        do_read(8'h20, 2'b10);
        chk(reg_rdata == 32'h0, "R2", "unmapped read", reg_rdata, 32'h0);
        do_read(8'h02, 2'b10);
        read_all();

        // R3: narrow accesses
        cur_tag = "R3";
        do_write(8'h04, 32'h0BAD_0BAD, 2'b01);
        do_write(8'h04, 32'h0BAD_0BAD, 2'b00);
        do_read(8'h04, 2'b10);
        chk(reg_rdata == (32'hA5C3_0F00 ^ 32'h0101_0101), "R3", "narrow write dropped", reg_rdata, 32'hA5C3_0F00 ^ 32'h0101_0101);
        do_read(8'h04, 2'b01);
        chk(reg_rvalid && reg_rdata == 32'h0, "R3", "narrow read zero", reg_rdata, 32'h0);

        // R5: back-to-back and sparse reads, read during write
        cur_tag = "R5";
        reg_rd_en = 1'b1; reg_addr = 8'h0C; tick(); reg_addr = 8'h18; tick(); reg_rd_en = 1'b0;
        tick(); tick();
        reg_rd_en = 1'b1; reg_wr_en = 1'b1; reg_addr = 8'h14; reg_wdata = 32'h5555_AAAA; tick();
        reg_rd_en = 1'b0; reg_wr_en = 1'b0;
        tick();
        do_read(8'h14, 2'b10);

        // R6: primary variant uses only the low nibble
        cur_tag = "R6";
        alt_board = 1'b0;
        do_write(8'h00, 32'hFFFF_FFF5, 2'b10);
        do_write(8'h04, 32'h0000_0003, 2'b10);
        do_write(8'h08, 32'h1234_567A, 2'b10);
        for (int s = 0; s < 3; s++) begin
            probe(2'(s), 32'h0);
            probe(2'(s), 32'h0001_2340);
        end
        probe(2'd0, 32'h0);
        chk(pci_addr == 32'h5000_0000, "R6", "nibble base", pci_addr, 32'h5000_0000);

        // R7: alternate variant masks by window size
        cur_tag = "R7";
        alt_board = 1'b1;
        do_write(8'h00, 32'h1234_5678, 2'b10);
        do_write(8'h04, 32'hABCD_EF01, 2'b10);
        do_write(8'h08, 32'hFFFF_FFFF, 2'b10);
        for (int s = 0; s < 3; s++) begin
            probe(2'(s), 32'h0);
            probe(2'(s), 32'h0000_0ABC);
        end
        probe(2'd1, 32'h10);
        chk(pci_addr == 32'hA800_0010, "R7", "masked base", pci_addr, 32'hA800_0010);

        // R8: size boundaries on both variants
        cur_tag = "R8";
        for (int v = 0; v < 2; v++) begin
            alt_board = v[0];
            for (int s = 0; s < 3; s++) begin
                probe(2'(s), (v == 1 ? alt_sz[s] : pri_sz[s]) - 32'h1);
                probe(2'(s), (v == 1 ? alt_sz[s] : pri_sz[s]));
                probe(2'(s), 32'hFFFF_FFFF);
                probe(2'(s), (v == 1 ? pri_sz[s] : alt_sz[s]));
            end
        end
        alt_board = 1'b0;
        probe(2'd0, 32'h0C00_0000);
        chk(pci_hit == 1'b0, "R8", "window 0 upper bound", 32'(pci_hit), 32'h0);

        // R9: I/O window ignores registers and variant
        cur_tag = "R9";
        for (int v = 0; v < 2; v++) begin
            alt_board = v[0];
            probe(2'd3, 32'h0);
            probe(2'd3, 32'h000F_FFFF);
            probe(2'd3, 32'h0010_0000);
            probe(2'd3, 32'h8000_0000);
        end
        probe(2'd3, 32'h000F_FFFF);
        chk(pci_hit && pci_addr == 32'h000F_FFFF, "R9", "io top byte", pci_addr, 32'h000F_FFFF);

        // R10: map write applies from the next cycle
        cur_tag = "R10";
        alt_board = 1'b0; xl_sel = 2'd0; xl_offset = 32'h100;
        tick();
        do_write(8'h00, 32'h0000_0007, 2'b10);
        chk(pci_addr == 32'h7000_0100, "R10", "new base", pci_addr, 32'h7000_0100);
        do_write(8'h00, 32'h0000_0002, 2'b10);
        tick();

        // R11: base plus offset up to the top of the space
        cur_tag = "R11";
        do_write(8'h04, 32'h0000_000F, 2'b10);
        probe(2'd1, 32'h0FFF_FFFF);
        chk(pci_addr == 32'hFFFF_FFFF, "R11", "top address", pci_addr, 32'hFFFF_FFFF);
        alt_board = 1'b1;
        do_write(8'h08, 32'hF800_0000, 2'b10);
        probe(2'd2, 32'h07FF_FFF0);
        chk(pci_addr == 32'hFFFF_FFF0, "R11", "alt sum", pci_addr, 32'hFFFF_FFF0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule